// File: doc/BRIEF.md
# SDRAM Extended-Mode Update Sequencer

This block rewrites the extended mode register of an SDRAM as part of a maintenance sequence the controller has to run anyway. The register holds three fields: partial-array self-refresh, temperature-compensated refresh and drive strength. A single request starts one of two paths. The self-refresh path ends with the SELF-REFRESH command and CKE low. The auto-refresh path performs an AUTO-REFRESH and then reopens the array with ACTIVATE. Because the register write is folded into one of these sequences, no separate maintenance window is needed.

When the pending-update flag is set at acceptance, a mode register set to the extended register (bank 2) is placed between the precharge and the refresh command. The field values are carried on the address pins during that command. If the flag is clear, that step and its wait are skipped. Each wait is counted in controller clocks from a programmable count. A request that arrives while a sequence is running is remembered and started right after the current one finishes.

Top module: `emr_seq`

## Requirements
- R1: Command codes on `cmd` are NOP=0, PRECHARGE ALL=1, MRS=2, AUTO-REFRESH=3, SELF-REFRESH=4, ACTIVATE=5. When `sr_sel`=1 at acceptance, the sequence is PRECHARGE ALL, then MRS, then SELF-REFRESH.
- R2: When `sr_sel`=0 at acceptance, the sequence is PRECHARGE ALL, then MRS, then AUTO-REFRESH, then ACTIVATE. ACTIVATE drives zero on `addr` and `ba`.
- R3: During MRS, `ba` equals 2. `addr[2:0]` carries the partial-array field, `addr[4:3]` carries temperature compensation and `addr[6:5]` carries drive strength. All other address bits are zero.
- R4: During PRECHARGE ALL, `addr[10]` is 1, all other address bits are 0 and `ba` is 0.
- R5: CKE stays high on the auto-refresh path. On the self-refresh path CKE goes low on the cycle after SELF-REFRESH, unless a new sequence starts on that cycle. It returns high when the next request is accepted.
- R6: `cmd` is NOP on every cycle that carries none of the listed commands, including every idle cycle.
- R7: The gaps between commands are set by the programmable counts. MRS follows PRECHARGE ALL by `t_rp` cycles. The refresh command follows MRS by `t_mrd` cycles. ACTIVATE follows AUTO-REFRESH by `t_rfc` cycles. A count of 0 acts as 1.
- R8: If `upd_pending` is 0 at acceptance, MRS and its `t_mrd` wait are skipped, and the refresh command follows PRECHARGE ALL by `t_rp` cycles.
- R9: A request pulse accepted on a clock edge puts PRECHARGE ALL on `cmd` in the following cycle. A request that arrives while busy is held and starts the cycle after `done`.
- R10: `busy` is high from the PRECHARGE ALL cycle through the final command (SELF-REFRESH or ACTIVATE). `done` is a one-cycle pulse coincident with that final command.
- R11: After reset, `cmd` is NOP, `cke` is 1, `addr` and `ba` are 0, and `busy` and `done` are 0.
- R12: Mode, update flag, field values and wait counts are captured at acceptance. Changes to those inputs during the sequence have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request pulse |
| upd_pending | input | 1 | Extended register rewrite wanted |
| sr_sel | input | 1 | 1 = self-refresh entry path, 0 = auto-refresh path |
| pasr | input | 3 | Partial-array self-refresh field |
| tcsr | input | 2 | Temperature-compensation field |
| drv | input | 2 | Drive-strength field |
| t_rp | input | CNT_W | Precharge-to-next wait count |
| t_mrd | input | CNT_W | MRS-to-next wait count |
| t_rfc | input | CNT_W | Auto-refresh-to-activate wait count |
| cmd | output | 3 | Command code |
| addr | output | ADDR_W | Address pins |
| ba | output | 2 | Bank address pins |
| cke | output | 1 | Clock enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |

## Verification
The bench builds the block with CNT_W=4 and ADDR_W=13. This keeps every count, from 0 (treated as 1) up to the full-scale 15, within a few cycles, so random draws cover both ends of each wait. With 13 address bits, bit 10 and the zero bits above the fields at 7 and up are visible. Random transactions sometimes inject a second request mid-sequence and change the inputs at the same time. This exercises the held request, the back-to-back start after a self-refresh (where CKE must stay high), and the capture of inputs at acceptance.

// File: rtl/emr_seq.sv
module emr_seq #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              upd_pending,
  input  logic              sr_sel,
  input  logic [2:0]        pasr,
  input  logic [1:0]        tcsr,
  input  logic [1:0]        drv,
  input  logic [CNT_W-1:0]  t_rp,
  input  logic [CNT_W-1:0]  t_mrd,
  input  logic [CNT_W-1:0]  t_rfc,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              cke,
  output logic              busy,
  output logic              done
);
  localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_MRS = 3'd2,
                         C_AREF = 3'd3, C_SREF = 3'd4, C_ACT = 3'd5;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_MRS, S_AREF, S_FIN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             sr_q, upd_q, held;
  logic [6:0]       fld_q;
  logic [CNT_W-1:0] mrd_q, rfc_q;

  function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] t);
    return (t == '0) ? ONE : t;
  endfunction

  wire can_start = (st == S_IDLE) || (st == S_FIN);
  wire start     = can_start && (req || held);
  wire last      = (cnt == ONE);

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd <= C_NOP; addr <= '0; ba <= '0; cke <= 1'b1;
      cnt <= '0; sr_q <= 1'b0; upd_q <= 1'b0; held <= 1'b0; fld_q <= '0;
      mrd_q <= '0; rfc_q <= '0;
    end else begin
      cmd  <= C_NOP;
      addr <= '0;
      ba   <= '0;
      if (req && !can_start) held <= 1'b1;
      case (st)
        S_IDLE, S_FIN: begin
          if (start) begin
            held  <= 1'b0;
            cmd   <= C_PRE;
            addr  <= ADDR_W'(1) << 10;
            cke   <= 1'b1;
            sr_q  <= sr_sel;
            upd_q <= upd_pending;
            fld_q <= {drv, tcsr, pasr};
            mrd_q <= eff(t_mrd);
            rfc_q <= eff(t_rfc);
            cnt   <= eff(t_rp);
            st    <= S_PRE;
          end else begin
            if (st == S_FIN && sr_q) cke <= 1'b0;
            st <= S_IDLE;
          end
        end
        S_PRE: begin
          if (!last) cnt <= cnt - ONE;
          else if (upd_q) begin
            cmd  <= C_MRS;
            ba   <= 2'd2;
            addr <= ADDR_W'(fld_q);
            cnt  <= mrd_q;
            st   <= S_MRS;
          end else if (sr_q) begin
            cmd <= C_SREF; st <= S_FIN;
          end else begin
            cmd <= C_AREF; cnt <= rfc_q; st <= S_AREF;
          end
        end
        S_MRS: begin
          if (!last) cnt <= cnt - ONE;
          else if (sr_q) begin
            cmd <= C_SREF; st <= S_FIN;
          end else begin
            cmd <= C_AREF; cnt <= rfc_q; st <= S_AREF;
          end
        end
        S_AREF: begin
          if (!last) cnt <= cnt - ONE;
          else begin
            cmd <= C_ACT; st <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module emr_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        ba,
  input logic              cke,
  input logic              busy,
  input logic              done
);
  p_mrs_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |-> (ba == 2'd2 && (addr >> 7) == '0));
  p_pre_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |-> (addr[10] && ba == 2'd0));
  p_cke_aref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3 || cmd == 3'd5 || cmd == 3'd1 || cmd == 3'd2) |-> cke);
  p_idle_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd == 3'd0));
  p_start_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd == 3'd1));
  p_done_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && (cmd == 3'd4 || cmd == 3'd5)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || (cmd == 3'd4 || cmd == 3'd5));
endmodule

bind emr_seq emr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .ba(ba),
  .cke(cke), .busy(busy), .done(done)
);

// File: tb/tb_emr_seq.sv
module tb_emr_seq;
  localparam int ADDR_W = 13;
  localparam int CNT_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, upd_pending = 1'b0, sr_sel = 1'b0;
  logic [2:0] pasr = '0;
  logic [1:0] tcsr = '0, drv = '0;
  logic [CNT_W-1:0] t_rp = '0, t_mrd = '0, t_rfc = '0;
  logic [2:0] cmd;
  logic [ADDR_W-1:0] addr;
  logic [1:0] ba;
  logic cke, busy, done;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  emr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .upd_pending(upd_pending), .sr_sel(sr_sel),
    .pasr(pasr), .tcsr(tcsr), .drv(drv), .t_rp(t_rp), .t_mrd(t_mrd), .t_rfc(t_rfc),
    .cmd(cmd), .addr(addr), .ba(ba), .cke(cke), .busy(busy), .done(done));

  typedef struct packed {
    logic sr, upd;
    logic [6:0] fld;
    logic [CNT_W-1:0] rp, mrd, rfc;
  } txn_t;

  function automatic int eff(input logic [CNT_W-1:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  function automatic int tail_at(input txn_t t);
    return eff(t.rp) + (t.upd ? eff(t.mrd) : 0);
  endfunction

  function automatic int final_at(input txn_t t);
    return tail_at(t) + (t.sr ? 0 : eff(t.rfc));
  endfunction

  function automatic logic [2:0] exp_cmd(input txn_t t, input int c);
    if (c == 0) return 3'd1;
    if (t.upd && c == eff(t.rp)) return 3'd2;
    if (c == tail_at(t)) return t.sr ? 3'd4 : 3'd3;
    if (!t.sr && c == final_at(t)) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input txn_t t, input logic [2:0] k);
    if (k == 3'd1) return ADDR_W'(1) << 10;
    if (k == 3'd2) return ADDR_W'(t.fld);
    return '0;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic apply(input txn_t t);
    sr_sel = t.sr; upd_pending = t.upd;
    {drv, tcsr, pasr} = t.fld;
    t_rp = t.rp; t_mrd = t.mrd; t_rfc = t.rfc;
  endtask

  // Called at the negedge where PRECHARGE ALL is expected; returns at the cycle after the final command.
  task automatic check_seq(input txn_t t, input bit inject, input txn_t nxt);
    int f;
    f = final_at(t);
    for (int c = 0; c <= f; c++) begin
      logic [2:0] ek;
      ek = exp_cmd(t, c);
      if (c > 0) begin
        if (inject && c == 1) begin req = 1'b1; apply(nxt); end
        else req = 1'b0;
      end
      chk(cmd == ek, ek == 3'd2 ? "R3 MRS" : (t.sr ? "R1 R7 R8 sr order" : "R2 R7 R8 ar order"), cmd, ek);
      chk(addr == exp_addr(t, ek), ek == 3'd1 ? "R4 pre addr" : "R3 R12 addr", addr, exp_addr(t, ek));
      chk(ba == ((ek == 3'd2) ? 2'd2 : 2'd0), "R3 bank", ba, (ek == 3'd2) ? 2 : 0);
      chk(cke == 1'b1, "R5 cke high", cke, 1);
      chk(busy == 1'b1, "R10 busy", busy, 1);
      chk(done == (c == f), "R10 done", done, c == f);
      @(negedge clk);
    end
    req = 1'b0;
    if (!inject) begin
      chk(busy == 1'b0 && cmd == 3'd0, "R6 idle nop", cmd, 0);
      chk(cke == !t.sr, "R5 cke after seq", cke, !t.sr);
    end
  endtask

  task automatic launch(input txn_t t);
    apply(t);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic run(input txn_t a, input bit inject, input txn_t b);
    launch(a);
    check_seq(a, inject, b);
    if (inject) begin
      chk(cmd == 3'd1, "R9 held start", cmd, 1);
      check_seq(b, 1'b0, b);
    end
    @(negedge clk);
  endtask

  function automatic txn_t rnd();
    txn_t t;
    t.sr = 1'($urandom); t.upd = 1'($urandom); t.fld = 7'($urandom);
    t.rp = CNT_W'($urandom); t.mrd = CNT_W'($urandom); t.rfc = CNT_W'($urandom);
    return t;
  endfunction

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    txn_t a, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cmd == 3'd0 && addr == '0 && ba == '0, "R11 reset outputs", cmd, 0);
    chk(cke == 1'b1 && !busy && !done, "R11 reset handshake", {cke, busy, done}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: zero counts, full-scale counts, no update, back-to-back after self-refresh
    a = '{sr:1'b1, upd:1'b1, fld:7'h5A, rp:'0, mrd:'0, rfc:'0};  run(a, 1'b0, a);
    a = '{sr:1'b0, upd:1'b1, fld:7'h7F, rp:'1, mrd:'1, rfc:'1};  run(a, 1'b0, a);
    a = '{sr:1'b0, upd:1'b0, fld:7'h33, rp:4'd3, mrd:4'd9, rfc:4'd2}; run(a, 1'b0, a);
    a = '{sr:1'b1, upd:1'b0, fld:7'h11, rp:4'd2, mrd:4'd9, rfc:4'd2}; run(a, 1'b0, a);
    a = '{sr:1'b1, upd:1'b1, fld:7'h25, rp:4'd2, mrd:4'd3, rfc:4'd1};
    b = '{sr:1'b0, upd:1'b1, fld:7'h4C, rp:4'd1, mrd:4'd2, rfc:4'd4}; run(a, 1'b1, b);
    for (int i = 0; i < 60; i++) begin
      a = rnd(); b = rnd();
      run(a, ($urandom % 4) == 0, b);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule